// File: doc/BRIEF.md
# Windowed Integer Register File

This block holds the integer registers of a pipeline that uses overlapping register windows. The pipeline always sees 32 architectural registers through 5-bit indices. Eight of them are globals, kept in one bank that stays in place. The other 24 come from a ring of windows. A current-window pointer picks which window supplies them.

Each window owns eight outgoing registers and eight private locals. Its eight incoming registers are physically the outgoing registers of the next window on the ring. A save moves the pointer down by one, so the callee's incoming group is the caller's outgoing group. A restore moves the pointer back up. The pipeline supplies a mask of windows that are not resident. A move whose target window is marked in that mask is refused and reported as overflow (on a save) or underflow (on a restore).

The block has two combinational read ports and one write port that commits on the clock edge. The number of windows is a parameter, from 2 to 32.

Top module: `winreg_file`

## Requirements
- R1: While reset is asserted and after it is released, the window pointer is 0 and every register reads 0.
- R2: Index 0 always reads 0. A write to index 0 changes nothing.
- R3: Indices 1–7 select the globals. Their contents are the same whatever window is current.
- R4: A write updates its register on the rising clock edge. A read of the same register in the same cycle returns the value held before that edge.
- R5: A save without overflow sets the pointer to pointer−1 modulo NWIN, so a save from 0 gives NWIN−1.
- R6: A restore without underflow sets the pointer to pointer+1 modulo NWIN, so a restore from NWIN−1 gives 0.
- R7: Indices 8–15 are the current window's outgoing group and indices 24–31 are its incoming group. After a save, the value the caller held at index 8+k reads back at index 24+k.
- R8: Indices 16–23 are locals private to each window. Locals written in one window are not visible from another window, and they are kept across a save/restore round trip.
- R9: When a save is requested and bit (pointer−1 mod NWIN) of the invalid mask is 1, `spill_trap` is 1 in that cycle and the pointer does not change.
- R10: When a restore alone is requested and bit (pointer+1 mod NWIN) of the invalid mask is 1, `fill_trap` is 1 in that cycle and the pointer does not change.
- R11: When save and restore are requested in the same cycle, the save takes effect and the restore is ignored. `fill_trap` stays 0.
- R12: The two read ports each return the register their own index selects, independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_a_idx | input | 5 | Architectural index for read port A |
| rd_a_data | output | XLEN | Read port A data (combinational) |
| rd_b_idx | input | 5 | Architectural index for read port B |
| rd_b_data | output | XLEN | Read port B data (combinational) |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Architectural index to write |
| wr_data | input | XLEN | Data to write |
| save_req | input | 1 | Move the window toward the callee |
| restore_req | input | 1 | Move the window toward the caller |
| invalid_win | input | NWIN | One bit per window; 1 marks a window that may not be entered |
| cur_win | output | clog2(NWIN) | Current window pointer |
| spill_trap | output | 1 | Save refused because the target window is invalid |
| fill_trap | output | 1 | Restore refused because the target window is invalid |

## Verification
The bench builds the block with NWIN=4 and XLEN=32. With four windows, a single save from reset wraps the pointer from 0 to 3, and a single restore wraps it back. The incoming group of window 3 is then the outgoing group of window 0, so the aliasing across the ring seam is checked within a few cycles. Four mask bits are also few enough to aim a refused save and a refused restore at specific windows next to the current one.

// File: rtl/winreg_file.sv
module winreg_file #(
  parameter int NWIN = 8,
  parameter int XLEN = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [4:0]           rd_a_idx,
  output logic [XLEN-1:0]      rd_a_data,
  input  logic [4:0]           rd_b_idx,
  output logic [XLEN-1:0]      rd_b_data,
  input  logic                 wr_en,
  input  logic [4:0]           wr_idx,
  input  logic [XLEN-1:0]      wr_data,
  input  logic                 save_req,
  input  logic                 restore_req,
  input  logic [NWIN-1:0]      invalid_win,
  output logic [$clog2(NWIN)-1:0] cur_win,
  output logic                 spill_trap,
  output logic                 fill_trap
);
  localparam int CW = $clog2(NWIN);
  localparam int AW = CW + 4;
  localparam int NW = NWIN * 16;

  logic [XLEN-1:0] gbank [8];
  logic [XLEN-1:0] wbank [NW];
  logic [CW-1:0]   cwp_q, cwp_up, cwp_dn;

  assign cwp_up = (cwp_q == CW'(NWIN - 1)) ? '0 : cwp_q + 1'b1;
  assign cwp_dn = (cwp_q == '0) ? CW'(NWIN - 1) : cwp_q - 1'b1;
  assign cur_win = cwp_q;

  function automatic logic [AW-1:0] slot(input logic [4:0] idx,
                                         input logic [CW-1:0] here,
                                         input logic [CW-1:0] above);
    logic [CW-1:0] w;
    w = (idx[4:3] == 2'b11) ? above : here;
    return {w, idx[4:3] == 2'b10, idx[2:0]};
  endfunction

  function automatic logic [XLEN-1:0] rd(input logic [4:0] idx);
    if (idx[4:3] == 2'b00) return (idx == 5'd0) ? '0 : gbank[idx[2:0]];
    return wbank[slot(idx, cwp_q, cwp_up)];
  endfunction

  assign rd_a_data = rd(rd_a_idx);
  assign rd_b_data = rd(rd_b_idx);

  assign spill_trap = save_req & invalid_win[cwp_dn];
  assign fill_trap  = restore_req & ~save_req & invalid_win[cwp_up];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cwp_q <= '0;
      for (int i = 0; i < 8; i++) gbank[i] <= '0;
      for (int i = 0; i < NW; i++) wbank[i] <= '0;
    end else begin
      if (wr_en && wr_idx[4:3] == 2'b00 && wr_idx != 5'd0)
        gbank[wr_idx[2:0]] <= wr_data;
      else if (wr_en && wr_idx[4:3] != 2'b00)
        wbank[slot(wr_idx, cwp_q, cwp_up)] <= wr_data;
      if (save_req && !spill_trap)
        cwp_q <= cwp_dn;
      else if (restore_req && !save_req && !fill_trap)
        cwp_q <= cwp_up;
    end
  end

  p_zero_idx_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_idx == 5'd0) |-> (rd_a_data == '0));
  p_save_move_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (save_req && !spill_trap) |=>
      (cur_win == (($past(cur_win) == '0) ? CW'(NWIN - 1) : $past(cur_win) - 1'b1)));
  p_restore_move_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (restore_req && !save_req && !fill_trap) |=>
      (cur_win == (($past(cur_win) == CW'(NWIN - 1)) ? '0 : $past(cur_win) + 1'b1)));
  p_spill_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    spill_trap |=> $stable(cur_win));
  p_fill_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fill_trap |=> $stable(cur_win));
  p_one_trap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(spill_trap && fill_trap));
  p_write_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx != 5'd0 && !save_req && !restore_req) |=>
      (rd_a_idx != $past(wr_idx) || rd_a_data == $past(wr_data)));
endmodule

// File: tb/test_winreg_file.sv
module test_winreg_file;
  localparam int NWIN = 4;
  localparam int XLEN = 32;

  logic clk = 0, rst_n = 0;
  logic [4:0] rd_a_idx = 0, rd_b_idx = 0, wr_idx = 0;
  logic [XLEN-1:0] rd_a_data, rd_b_data, wr_data = 0;
  logic wr_en = 0, save_req = 0, restore_req = 0;
  logic [NWIN-1:0] invalid_win = 0;
  logic [1:0] cur_win;
  logic spill_trap, fill_trap;
  int n_cmp = 0, n_bad = 0;

  always #10 clk = ~clk;

  winreg_file #(.NWIN(NWIN), .XLEN(XLEN)) i_winreg_file (
    .clk, .rst_n, .rd_a_idx, .rd_a_data, .rd_b_idx, .rd_b_data,
    .wr_en, .wr_idx, .wr_data, .save_req, .restore_req, .invalid_win,
    .cur_win, .spill_trap, .fill_trap);

  localparam logic [4:0]  VIDX [8] = '{5'd0, 5'd1, 5'd7, 5'd8, 5'd15, 5'd16, 5'd23, 5'd31};
  localparam logic [31:0] VDAT [8] = '{32'hDEAD_0000, 32'h1111_0001, 32'h7777_0007, 32'h8888_0008,
                                       32'hF0F0_000F, 32'h1616_0010, 32'h2323_0017, 32'h3131_001F};
  localparam logic [31:0] VEXP [8] = '{32'h0, 32'h1111_0001, 32'h7777_0007, 32'h8888_0008,
                                       32'hF0F0_000F, 32'h1616_0010, 32'h2323_0017, 32'h3131_001F};

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] idx, input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_idx = idx; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic move(input logic s, input logic r);
    @(negedge clk); save_req = s; restore_req = r;
    @(negedge clk); save_req = 0; restore_req = 0;
  endtask

  task automatic rdchk(input string tag, input logic [4:0] idx, input logic [31:0] exp);
    rd_a_idx = idx; #1; chk(tag, rd_a_data, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R1 cur_win in reset", 32'(cur_win), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 cur_win", 32'(cur_win), 0);
    rdchk("R1 reg 5", 5'd5, 0);
    rdchk("R1 reg 20", 5'd20, 0);
    chk("R1 traps", {30'd0, spill_trap, fill_trap}, 0);

    for (int i = 0; i < 8; i++) begin
      wr(VIDX[i], VDAT[i]);
      rd_a_idx = VIDX[i]; rd_b_idx = VIDX[7 - i]; #1;
      chk("R2/R12 port A", rd_a_data, VEXP[i]);
    end
    for (int i = 0; i < 8; i++) begin
      rd_a_idx = VIDX[i]; rd_b_idx = VIDX[7 - i]; #1;
      chk("R12 port A", rd_a_data, VEXP[i]);
      chk("R12 port B", rd_b_data, VEXP[7 - i]);
    end

    @(negedge clk); wr_en = 1; wr_idx = 5'd9; wr_data = 32'hABCD_0009; rd_a_idx = 5'd9; #1;
    chk("R4 old value before edge", rd_a_data, 0);
    @(negedge clk); wr_en = 0; #1;
    chk("R4 new value after edge", rd_a_data, 32'hABCD_0009);

    move(1, 0);
    chk("R5 save wraps", 32'(cur_win), 3);
    rdchk("R7 caller out 8 at in 24", 5'd24, 32'h8888_0008);
    rdchk("R7 caller out 9 at in 25", 5'd25, 32'hABCD_0009);
    rdchk("R8 fresh window locals", 5'd16, 0);
    rdchk("R3 global 1 after save", 5'd1, 32'h1111_0001);
    wr(5'd16, 32'h5A5A_0316);
    rdchk("R8 local in window 3", 5'd16, 32'h5A5A_0316);

    move(0, 1);
    chk("R6 restore wraps", 32'(cur_win), 0);
    rdchk("R8 window 0 local kept", 5'd16, 32'h1616_0010);
    rdchk("R8 window 0 local 23 kept", 5'd23, 32'h2323_0017);
    rdchk("R3 global 7 after restore", 5'd7, 32'h7777_0007);

    move(0, 1);
    chk("R6 restore 0 to 1", 32'(cur_win), 1);
    rdchk("R7 window 1 out 15 is window 0 in 31", 5'd15, 32'h3131_001F);
    move(1, 0);
    chk("R5 save 1 to 0", 32'(cur_win), 0);

    invalid_win = 4'b1000;
    @(negedge clk); save_req = 1; #1;
    chk("R9 spill_trap", 32'(spill_trap), 1);
    @(negedge clk); save_req = 0; #1;
    chk("R9 cur_win held", 32'(cur_win), 0);
    chk("R9 spill_trap clears", 32'(spill_trap), 0);

    invalid_win = 4'b0010;
    @(negedge clk); restore_req = 1; #1;
    chk("R10 fill_trap", 32'(fill_trap), 1);
    @(negedge clk); restore_req = 0; #1;
    chk("R10 cur_win held", 32'(cur_win), 0);

    @(negedge clk); save_req = 1; restore_req = 1; #1;
    chk("R11 no fill_trap with save", 32'(fill_trap), 0);
    @(negedge clk); save_req = 0; restore_req = 0; #1;
    chk("R11 save wins", 32'(cur_win), 3);
    invalid_win = 0;

    wr(5'd0, 32'hFFFF_FFFF);
    rdchk("R2 index 0 ignores write", 5'd0, 0);

    @(negedge clk); rst_n = 0; #1;
    rdchk("R1 global cleared", 5'd1, 0);
    chk("R1 pointer cleared", 32'(cur_win), 0);
    @(negedge clk); rst_n = 1;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule